// File: doc/BRIEF.md
# Stereo PCM Serial Output Port

This block turns stereo PCM sample pairs into a three-wire serial stream made of a bit clock, a frame clock and one data line. Each half of the frame clock carries one channel in 32 bit slots, and the sample word of width `W` is sent MSB first. Four format inputs choose the word placement, a one-slot MSB delay, the bit-clock edge on which data moves, and which frame-clock level means "left". These inputs may be changed at run time.

In master mode the port makes both clocks from its system clock. The bit clock has a period of `2*HALF_DIV` system clocks, and the frame clock toggles once per 32 bit clocks. In slave mode the port takes both clocks from pins, synchronizes them into its own clock domain and follows their edges.

A source pushes a left/right pair with a one-cycle valid strobe into a one-pair holding register. The pair is copied into the frame registers at the start of each left half-frame. When the source and the frame clock run at different rates, a pair is overwritten or sent twice. Both cases raise a one-cycle slip pulse.

Top module: `aud_ser_port`

## Requirements
- R1: While reset is asserted, and until the first bit-clock edge after it, `sdata`, `bclk_out`, `lrck_out` and `slip` are all 0.
- R2: In master mode `bclk_out` has a period of `2*HALF_DIV` clock cycles. `lrck_out` changes only together with a bit-clock edge of the data-driving kind. Its first change after reset is a rise, and it then holds each level for 32 bit-clock periods.
- R3: `sdata` changes only on the driving edge of the bit clock: the falling edge when `cfg_edge`=0 and the rising edge when `cfg_edge`=1. A receiver samples on the opposite edge.
- R4: With `cfg_rjust`=0, number the slots of a half-frame 0 to 31, counting from the first slot after a frame-clock change. The word MSB sits in slot 0 when `cfg_dly`=0 and in slot 1 when `cfg_dly`=1. The bits then follow down to the LSB, and all other slots are 0.
- R5: With `cfg_lrpol`=0 a high frame clock carries the left word; with `cfg_lrpol`=1 a high frame clock carries the right word.
- R6: In master mode with `cfg_rjust`=1, the LSB sits in slot 31 and the MSB in slot 32-W. Slots 0 to 31-W are 0, and `cfg_dly` has no effect.
- R7: In slave mode `cfg_rjust` is ignored, and the output follows the left-justified layout of R4.
- R8: In slave mode the port follows `bclk_in` and `lrck_in`, and it holds `bclk_out` and `lrck_out` at 0.
- R9: A pair is taken when `smp_valid` is 1. It is sent in the next left half-frame and in the right half-frame that follows. A second pair that arrives before that left half-frame overwrites the first (a drop), and `slip` pulses for one cycle.
- R10: If no new pair has arrived by a left half-frame start, the previous pair is sent again (a repeat) and `slip` pulses. Before the first pair ever arrives, nothing counts as a repeat, and slip stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate clocks, 0: follow clock pins |
| cfg_rjust | input | 1 | 0: left-justified, 1: right-justified (master only) |
| cfg_dly | input | 1 | 1: MSB one slot late in left-justified layout |
| cfg_edge | input | 1 | 0: data moves on falling edge, 1: on rising edge |
| cfg_lrpol | input | 1 | 0: frame clock high is left, 1: high is right |
| smp_valid | input | 1 | One-cycle strobe: new pair present |
| smp_left | input | W | Left sample word |
| smp_right | input | W | Right sample word |
| bclk_in | input | 1 | Bit clock in slave mode |
| lrck_in | input | 1 | Frame clock in slave mode |
| bclk_out | output | 1 | Bit clock in master mode, 0 in slave mode |
| lrck_out | output | 1 | Frame clock in master mode, 0 in slave mode |
| sdata | output | 1 | Serial data line |
| slip | output | 1 | One-cycle pulse on a dropped or repeated pair |

## Verification
The bench deserializes the data line on the receiving edge and rebuilds both words. It does this for all 16 format combinations in master mode and again in slave mode, with a different word pattern per run, so a swapped channel, a misplaced MSB, a wrong edge or a bad pad bit each shows up as a word mismatch or a nonzero pad slot. The slave runs with right justification set tell an ignored select apart from an obeyed one. Three timing patterns of the pair strobe separate the slip causes: one pair per frame (no slip), two pairs before a frame (drop, the later pair is sent), and one pair then silence (repeats, with no slip before the first pair).

// File: rtl/aud_ser_pkg.sv
`timescale 1ns/1ps
package aud_ser_pkg;
  localparam int SLOTS_PER_HALF = 32;
  localparam int POS_W = $clog2(SLOTS_PER_HALF);
  typedef logic [POS_W-1:0] pos_t;
  localparam pos_t POS_LAST = pos_t'(SLOTS_PER_HALF - 1);

  typedef struct packed {
    logic rjust;
    logic dly;
    logic edge_sel;
    logic lrpol;
  } fmt_t;
endpackage

// File: rtl/aud_ser_clkgen.sv
`timescale 1ns/1ps
module aud_ser_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic edge_sel,
  input  logic bclk_in,
  input  logic lrck_in,
  output logic drv_evt,
  output logic bclk_q,
  output logic lrck_sync
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bclk_d;
  logic          tick;
  logic [2:0]    bsync_q, bsync_d;
  logic [1:0]    lsync_q, lsync_d;
  logic          rise, fall;

  always_comb begin
    tick    = master && (cnt_q == CNT_LAST);
    cnt_d   = cnt_q;
    bclk_d  = bclk_q;
    if (!master) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
    bsync_d = {bsync_q[1:0], bclk_in};
    lsync_d = {lsync_q[0], lrck_in};
    if (master) begin
      rise = tick && !bclk_q;
      fall = tick && bclk_q;
    end else begin
      rise = bsync_q[1] && !bsync_q[2];
      fall = !bsync_q[1] && bsync_q[2];
    end
    drv_evt = edge_sel ? rise : fall;
  end

  assign lrck_sync = lsync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bclk_q  <= 1'b0;
      bsync_q <= '0;
      lsync_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      bclk_q  <= bclk_d;
      bsync_q <= bsync_d;
      lsync_q <= lsync_d;
    end
  end
endmodule

// File: rtl/aud_ser_frame.sv
`timescale 1ns/1ps
module aud_ser_frame
  import aud_ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drv_evt,
  input  logic master,
  input  logic lrck_sync,
  input  logic lrpol,
  output pos_t bitpos_q,
  output pos_t bitpos_d,
  output logic lrck_q,
  output logic left_now,
  output logic left_start
);
  logic lrck_now;
  logic lrck_d;
  logic half_start;

  always_comb begin
    if (master) lrck_now = (bitpos_q == POS_LAST) ? ~lrck_q : lrck_q;
    else        lrck_now = lrck_sync;
    half_start = drv_evt && (lrck_now != lrck_q);
    left_now   = lrck_now ^ lrpol;
    left_start = half_start && left_now;
    bitpos_d   = bitpos_q;
    lrck_d     = lrck_q;
    if (drv_evt) begin
      lrck_d = lrck_now;
      if (half_start)                bitpos_d = '0;
      else if (bitpos_q != POS_LAST) bitpos_d = bitpos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitpos_q <= POS_LAST;
      lrck_q   <= 1'b0;
    end else begin
      bitpos_q <= bitpos_d;
      lrck_q   <= lrck_d;
    end
  end
endmodule

// File: rtl/aud_ser_hold.sv
`timescale 1ns/1ps
module aud_ser_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_left,
  input  logic [W-1:0] smp_right,
  input  logic         load,
  output logic [W-1:0] frm_l_d,
  output logic [W-1:0] frm_r_d,
  output logic         slip_q
);
  logic [W-1:0] hold_l_q, hold_r_q, hold_l_d, hold_r_d;
  logic [W-1:0] frm_l_q, frm_r_q;
  logic         full_q, full_d;
  logic         primed_q, primed_d;
  logic         slip_d;
  logic         drop, rep;

  always_comb begin
    frm_l_d  = frm_l_q;
    frm_r_d  = frm_r_q;
    hold_l_d = hold_l_q;
    hold_r_d = hold_r_q;
    full_d   = full_q;
    rep      = 1'b0;
    drop     = smp_valid && full_q && !load;
    primed_d = primed_q | smp_valid;
    if (load) begin
      if (full_q) begin
        frm_l_d = hold_l_q;
        frm_r_d = hold_r_q;
      end else if (smp_valid) begin
        frm_l_d = smp_left;
        frm_r_d = smp_right;
      end else begin
        rep = primed_q;
      end
    end
    if (smp_valid) begin
      if (!(load && !full_q)) begin
        hold_l_d = smp_left;
        hold_r_d = smp_right;
        full_d   = 1'b1;
      end
    end else if (load) begin
      full_d = 1'b0;
    end
    slip_d = drop | rep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      frm_l_q  <= '0;
      frm_r_q  <= '0;
      full_q   <= 1'b0;
      primed_q <= 1'b0;
      slip_q   <= 1'b0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      frm_l_q  <= frm_l_d;
      frm_r_q  <= frm_r_d;
      full_q   <= full_d;
      primed_q <= primed_d;
      slip_q   <= slip_d;
    end
  end
endmodule

// File: rtl/aud_ser_bitsel.sv
`timescale 1ns/1ps
module aud_ser_bitsel
  import aud_ser_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] word,
  input  pos_t         pos,
  input  logic         rjust,
  input  logic         dly,
  output logic         bit_o
);
  localparam int AW = POS_W + 1;

  logic [AW-1:0] lj_amt;
  pos_t          rj_amt;
  logic [W-1:0]  lj_sh, rj_sh;

  always_comb begin
    lj_amt = {1'b0, pos} - AW'(dly);
    lj_sh  = word << lj_amt;
    rj_amt = POS_LAST - pos;
    rj_sh  = word >> rj_amt;
    bit_o  = rjust ? rj_sh[0] : lj_sh[W-1];
  end
endmodule

// File: rtl/aud_ser_port.sv
`timescale 1ns/1ps
module aud_ser_port
  import aud_ser_pkg::*;
#(
  parameter int W        = 24,
  parameter int HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_master,
  input  logic         cfg_rjust,
  input  logic         cfg_dly,
  input  logic         cfg_edge,
  input  logic         cfg_lrpol,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_left,
  input  logic [W-1:0] smp_right,
  input  logic         bclk_in,
  input  logic         lrck_in,
  output logic         bclk_out,
  output logic         lrck_out,
  output logic         sdata,
  output logic         slip
);
  logic   rst_ff1_q, rst_sync_n;
  fmt_t   fmt;
  logic   drv_evt, mbclk, lrck_sync;
  pos_t   bitpos_q, bitpos_d;
  logic   lrck_q, left_now, left_start;
  logic [W-1:0] frm_l_d, frm_r_d, word;
  logic   bit_nxt, sdata_q, sdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff1_q  <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_ff1_q  <= 1'b1;
      rst_sync_n <= rst_ff1_q;
    end
  end

  always_comb begin
    fmt.rjust    = cfg_rjust & cfg_master;
    fmt.dly      = cfg_dly;
    fmt.edge_sel = cfg_edge;
    fmt.lrpol    = cfg_lrpol;
  end

  aud_ser_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .master    (cfg_master),
    .edge_sel  (fmt.edge_sel),
    .bclk_in   (bclk_in),
    .lrck_in   (lrck_in),
    .drv_evt   (drv_evt),
    .bclk_q    (mbclk),
    .lrck_sync (lrck_sync)
  );

  aud_ser_frame i_frame (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .drv_evt    (drv_evt),
    .master     (cfg_master),
    .lrck_sync  (lrck_sync),
    .lrpol      (fmt.lrpol),
    .bitpos_q   (bitpos_q),
    .bitpos_d   (bitpos_d),
    .lrck_q     (lrck_q),
    .left_now   (left_now),
    .left_start (left_start)
  );

  aud_ser_hold #(.W(W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .smp_valid (smp_valid),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .load      (left_start),
    .frm_l_d   (frm_l_d),
    .frm_r_d   (frm_r_d),
    .slip_q    (slip)
  );

  assign word = left_now ? frm_l_d : frm_r_d;

  aud_ser_bitsel #(.W(W)) i_bitsel (
    .word  (word),
    .pos   (bitpos_d),
    .rjust (fmt.rjust),
    .dly   (fmt.dly),
    .bit_o (bit_nxt)
  );

  always_comb begin
    sdata_d = sdata_q;
    if (drv_evt) sdata_d = bit_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sdata_q <= 1'b0;
    else             sdata_q <= sdata_d;
  end

  assign sdata    = sdata_q;
  assign bclk_out = cfg_master ? mbclk : 1'b0;
  assign lrck_out = cfg_master ? lrck_q : 1'b0;
endmodule

// File: rtl/aud_ser_port_chk.sv
`timescale 1ns/1ps
module aud_ser_port_chk
  import aud_ser_pkg::*;
#(
  parameter int W = 24
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_rjust,
  input logic cfg_edge,
  input logic smp_valid,
  input logic left_start,
  input pos_t bitpos_q,
  input logic bclk_out,
  input logic lrck_out,
  input logic sdata,
  input logic slip
);
  localparam pos_t LEAD = pos_t'(SLOTS_PER_HALF - W);

  // R3: in master mode data moves only where the bit clock reaches its driving level
  a_r3_data_on_drive_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && !$stable(sdata))
      |-> (!$stable(bclk_out) && (bclk_out == cfg_edge)));

  // R2: frame clock moves together with a driving bit-clock edge
  a_r2_frame_on_drive_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && !$stable(lrck_out))
      |-> (!$stable(bclk_out) && (bclk_out == cfg_edge)));

  // R6: leading slots of a right-justified half-frame are zero
  a_r6_rjust_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_rjust && $past(cfg_master) && $past(cfg_rjust)
      && (bitpos_q < LEAD)) |-> (sdata == 1'b0));

  // R9 and R10: a slip follows either a new pair or a left half-frame start
  a_r9_slip_cause: assert property (@(posedge clk) disable iff (!rst_n)
    slip |-> ($past(smp_valid) || $past(left_start)));
endmodule

bind aud_ser_port aud_ser_port_chk #(.W(W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_master (cfg_master),
  .cfg_rjust  (cfg_rjust),
  .cfg_edge   (cfg_edge),
  .smp_valid  (smp_valid),
  .left_start (left_start),
  .bitpos_q   (bitpos_q),
  .bclk_out   (bclk_out),
  .lrck_out   (lrck_out),
  .sdata      (sdata),
  .slip       (slip)
);

// File: tb/test_aud_ser_port.sv
`timescale 1ns/1ps
module test_aud_ser_port;
  localparam int W  = 24;
  localparam int HD = 2;
  localparam int SH = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_master, cfg_rjust, cfg_dly, cfg_edge, cfg_lrpol;
  logic smp_valid, bclk_in, lrck_in;
  logic [W-1:0] smp_left, smp_right;
  logic bclk_out, lrck_out, sdata, slip;

  aud_ser_port #(.W(W), .HALF_DIV(HD)) i_aud_ser_port (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_rjust(cfg_rjust),
    .cfg_dly(cfg_dly), .cfg_edge(cfg_edge), .cfg_lrpol(cfg_lrpol),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .bclk_in(bclk_in), .lrck_in(lrck_in), .bclk_out(bclk_out),
    .lrck_out(lrck_out), .sdata(sdata), .slip(slip)
  );

  int n_chk = 0;
  int n_err = 0;
  int slip_tot = 0;
  int pad_err;
  logic cur_master, cur_rj, cur_dly, cur_edge, cur_pol;
  logic s_lr;
  int   s_cnt;
  logic [W-1:0] cap_l [0:3];
  logic [W-1:0] cap_r [0:3];

  always @(posedge clk) if (slip === 1'b1) slip_tot <= slip_tot + 1;

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int run, input int k, input int right);
    logic [31:0] x;
    x = (run * 131 + k * 17 + right * 7 + 1) * 32'h9E3779B1;
    x = x ^ (x >> 11);
    return x[W-1:0];
  endfunction

  task automatic do_reset(input logic rj, input logic dl, input logic ed,
                          input logic pl);
    cur_rj = rj; cur_dly = dl; cur_edge = ed; cur_pol = pl;
    rst_n = 1'b0;
    cfg_master = 1'b0; cfg_rjust = rj; cfg_dly = dl; cfg_edge = ed; cfg_lrpol = pl;
    smp_valid = 1'b0; smp_left = '0; smp_right = '0;
    bclk_in = ~ed; lrck_in = 1'b0;
    s_lr = 1'b0; s_cnt = 31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic get_bit(output logic d, output logic l);
    if (cur_master) begin
      if (!cur_edge) @(posedge bclk_out);
      else           @(negedge bclk_out);
      #1;
      d = sdata; l = lrck_out;
    end else begin
      if (s_cnt == 31) begin s_lr = ~s_lr; s_cnt = 0; end
      else s_cnt++;
      @(negedge clk);
      bclk_in = cur_edge; lrck_in = s_lr;
      repeat (SH) @(negedge clk);
      bclk_in = ~cur_edge;
      d = sdata; l = s_lr;
      repeat (SH - 1) @(negedge clk);
    end
  endtask

  function automatic logic [W-1:0] decode(input logic [31:0] b, input logic rj,
                                          input logic dl, output bit bad);
    logic [W-1:0] w;
    bit in_word;
    w = '0;
    bad = 0;
    for (int j = 0; j < W; j++) begin
      if (rj) w[j] = b[31-j];
      else    w[W-1-j] = b[j+int'(dl)];
    end
    for (int i = 0; i < 32; i++) begin
      in_word = rj ? (i >= 32 - W) : (i >= int'(dl) && i < int'(dl) + W);
      if (!in_word && b[i]) bad = 1;
    end
    return w;
  endfunction

  task automatic capture(input int nfr, input bit do_push, input int run, input int k0);
    int nf = 0;
    int cnt = 0;
    int nb = 0;
    int kp = k0;
    bit have_left = 0;
    bit bad;
    logic prev = 1'b0;
    logic d, l;
    logic [31:0] sbuf = '0;
    logic [W-1:0] w;
    while (nf < nfr && nb < 64 * (nfr + 3)) begin
      get_bit(d, l);
      nb++;
      if (l !== prev) begin
        if (cnt == 32) begin
          w = decode(sbuf, cur_rj & cur_master, cur_dly, bad);
          if ((prev ^ cur_pol) == 1'b1) begin
            cap_l[nf] = w; have_left = 1;
            if (bad) pad_err++;
          end else if (have_left) begin
            cap_r[nf] = w; nf++;
            if (bad) pad_err++;
          end
        end
        cnt = 0;
        if (((l ^ cur_pol) == 1'b1) && do_push) begin
          push(pat(run, kp, 0), pat(run, kp, 1));
          kp++;
        end
      end
      if (cnt < 32) sbuf[cnt] = d;
      cnt++;
      prev = l;
    end
    check(nf == nfr, "R9 frames captured", nf, nfr);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; cfg_master = 1'b1; cfg_rjust = 1'b0; cfg_dly = 1'b0;
    cfg_edge = 1'b0; cfg_lrpol = 1'b0; smp_valid = 1'b0; smp_left = '0;
    smp_right = '0; bclk_in = 1'b0; lrck_in = 1'b0;
    repeat (4) @(negedge clk);
    check({sdata, bclk_out, lrck_out, slip} == 4'b0000, "R1 outputs in reset",
          {sdata, bclk_out, lrck_out, slip}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({sdata, bclk_out, lrck_out, slip} == 4'b0000, "R1 outputs after release",
          {sdata, bclk_out, lrck_out, slip}, 0);
  endtask

  task automatic test_master_clocks();
    realtime t0, t1;
    int n;
    do_reset(0, 0, 0, 0);
    cur_master = 1'b1;
    cfg_master = 1'b1;
    @(posedge lrck_out or negedge lrck_out);
    #1;
    check(lrck_out == 1'b1, "R2 first frame edge rises", lrck_out, 1);
    @(posedge bclk_out);
    t0 = $realtime;
    @(posedge bclk_out);
    t1 = $realtime;
    check((t1 - t0) == 2.0 * HD * 5.0, "R2 bit clock period ns", int'(t1 - t0),
          2 * HD * 5);
    @(negedge lrck_out);
    n = 0;
    while (1) begin
      @(posedge bclk_out or posedge lrck_out);
      #1;
      if (lrck_out) break;
      n++;
    end
    check(n == 32, "R2 bit clocks per half-frame", n, 32);
  endtask

  task automatic run_cfg(input int run, input logic m, input logic rj,
                         input logic dl, input logic ed, input logic pl);
    int base;
    do_reset(rj, dl, ed, pl);
    cur_master = m;
    pad_err = 0;
    base = slip_tot;
    push(pat(run, 0, 0), pat(run, 0, 1));
    cfg_master = m;
    capture(3, 1, run, 1);
    for (int k = 0; k < 3; k++) begin
      check(cap_l[k] == pat(run, k, 0), "R3 R4 R5 R6 R7 left word", cap_l[k],
            pat(run, k, 0));
      check(cap_r[k] == pat(run, k, 1), "R3 R4 R5 R6 R7 right word", cap_r[k],
            pat(run, k, 1));
    end
    check(pad_err == 0, "R4 R6 pad slots zero", pad_err, 0);
    check(slip_tot == base, "R9 no slip at matched rate", slip_tot - base, 0);
    if (!m) check(!bclk_out && !lrck_out, "R8 clock outputs low in slave",
                  {bclk_out, lrck_out}, 0);
  endtask

  task automatic test_no_prime();
    int base;
    do_reset(0, 0, 0, 0);
    cur_master = 1'b0;
    base = slip_tot;
    capture(1, 0, 40, 0);
    check(slip_tot == base, "R10 no slip before first pair", slip_tot - base, 0);
    push(pat(40, 0, 0), pat(40, 0, 1));
    capture(1, 0, 40, 1);
    check(cap_l[0] == pat(40, 0, 0), "R10 first pair after idle", cap_l[0],
          pat(40, 0, 0));
  endtask

  task automatic test_repeat();
    int base;
    do_reset(0, 0, 0, 0);
    cur_master = 1'b0;
    base = slip_tot;
    push(pat(41, 0, 0), pat(41, 0, 1));
    capture(2, 0, 41, 1);
    check(cap_l[1] == pat(41, 0, 0), "R10 repeated left", cap_l[1], pat(41, 0, 0));
    check(cap_r[1] == pat(41, 0, 1), "R10 repeated right", cap_r[1], pat(41, 0, 1));
    check(slip_tot - base == 2, "R10 slip per repeat", slip_tot - base, 2);
  endtask

  task automatic test_drop();
    int base;
    do_reset(0, 0, 0, 0);
    cur_master = 1'b0;
    base = slip_tot;
    push(pat(42, 0, 0), pat(42, 0, 1));
    push(pat(42, 9, 0), pat(42, 9, 1));
    capture(1, 1, 42, 1);
    check(cap_l[0] == pat(42, 9, 0), "R9 later pair kept left", cap_l[0],
          pat(42, 9, 0));
    check(cap_r[0] == pat(42, 9, 1), "R9 later pair kept right", cap_r[0],
          pat(42, 9, 1));
    check(slip_tot - base == 1, "R9 slip on drop", slip_tot - base, 1);
  endtask

  initial begin
    cur_master = 1'b0; cur_rj = 1'b0; cur_dly = 1'b0; cur_edge = 1'b0; cur_pol = 1'b0;
    pad_err = 0;
    test_reset();
    test_master_clocks();
    for (int m = 1; m >= 0; m--) begin
      for (int c = 0; c < 16; c++) begin
        run_cfg(m * 16 + c, m[0], c[3], c[2], c[1], c[0]);
      end
    end
    test_no_prime();
    test_repeat();
    test_drop();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule